// File: doc/BRIEF.md
# Coherent Time Snapshot Bank

This block keeps a shadow copy of the seven clock fields: hundredths, seconds, minutes, hours, day, month and year. A tracking flag decides what the copy does. While the flag is set, every update strobe from the live counter chain loads all seven fields at once. While it is clear, the copy is frozen. Software can therefore read the fields one byte at a time without checking for a carry partway through the read.

The host sets or clears the flag with a write and can read back its current value. A power-fail event clears the flag in hardware. The snapshot then keeps the last time loaded before the outage, with no host action needed. This works only if the host set the flag before power failed. The live counters and the bus decoding sit outside the block. The block receives the counter values as one flat vector together with a single-cycle update strobe.

Top module: `time_snapshot_bank`

## Requirements
- R1: While reset is applied, and after it is released, every snapshot field reads 0 and the tracking flag reads 0.
- R2: When the tracking flag is 1 and the update strobe is high at a clock edge, all seven snapshot fields take the live values on that same edge.
- R3: With no update strobe, the snapshot holds its value even while the tracking flag is 1 and the live inputs change.
- R4: Once the tracking flag is 0, update strobes have no effect on the snapshot. This holds across a full rollover such as 23:59:59.99 to 00:00:00.00.
- R5: A host write sets the tracking flag to the written bit, and the flag port shows the new value from the cycle after the write.
- R6: A rising edge on the power-fail input clears the tracking flag on that edge. An update strobe in that same cycle still loads, because the flag was set when it arrived, and later strobes are ignored.
- R7: When a power-fail rising edge and a host write arrive in the same cycle, the flag ends at 0.
- R8: If the flag is already 0 when power fails, the snapshot keeps its earlier frozen contents.
- R9: Only the rising edge of the power-fail input counts as an event. While the input stays high, a host write may set the flag again, and tracking then resumes.
- R10: Field k occupies bits [8k+7:8k] of both the live and the snapshot vectors, in this order: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day, 5 month, 6 year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. It is released synchronously inside the block |
| live_fields_i | input | 56 | Live counter fields, packed as described in R10 |
| live_upd_i | input | 1 | One-cycle strobe marking a new value on live_fields_i |
| en_wr_i | input | 1 | Host write strobe for the tracking flag |
| en_wdata_i | input | 1 | Value written to the tracking flag |
| pwr_fail_i | input | 1 | Power-fail indication. Its rising edge is the event |
| snap_fields_o | output | 56 | Snapshot fields, packed like the live vector |
| track_en_o | output | 1 | Current value of the tracking flag |

## Verification
A wrong tracking flag shows on track_en_o one cycle after the write or event that set it. When the flag is wrong, the snapshot either loads a strobe it should have ignored, or it misses one it should have taken, and the difference is visible on snap_fields_o right after that strobe's edge. A load enable wired per field would show as a mix of old and new bytes right after a rollover strobe. The scoreboard compares the whole 56-bit vector every cycle, so each of these faults appears within one cycle of the stimulus that exposes it.

// File: rtl/snap_pkg.sv
package snap_pkg;

  localparam int unsigned SNAP_FIELD_W   = 8;
  localparam int unsigned SNAP_NUM_FIELD = 7;

  // host and event controls seen by the tracking-flag logic
  typedef struct packed {
    logic wr;
    logic wdata;
    logic pf;
  } snap_ctl_t;

endpackage

// File: rtl/snap_rst_sync.sv
module snap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/snap_enable_ctrl.sv
module snap_enable_ctrl
  import snap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  snap_ctl_t ctl_i,
  output logic      en_o
);

  logic pf_q, pf_d;
  logic en_q, en_d;
  logic pf_evt;

  // event is the rising edge only; a held level does not re-clear
  assign pf_evt = ctl_i.pf & ~pf_q;

  always_comb begin
    pf_d = ctl_i.pf;
    en_d = en_q;
    if (pf_evt) begin
      en_d = 1'b0;               // hardware clear has priority
    end else if (ctl_i.wr) begin
      en_d = ctl_i.wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q <= 1'b0;
      en_q <= 1'b0;
    end else begin
      pf_q <= pf_d;
      en_q <= en_d;
    end
  end

  assign en_o = en_q;

  // R6 / R7: a power-fail edge always leaves the flag clear
  assert_pf_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i.pf && !pf_q) |=> !en_q);

  // R5: a plain write lands one cycle later
  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i.wr && !(ctl_i.pf && !pf_q)) |=> (en_q == $past(ctl_i.wdata)));

  // R5: the flag only rises through a host write of 1
  assert_rise_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(ctl_i.wr && ctl_i.wdata));

endmodule

// File: rtl/snap_field_reg.sv
module snap_field_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (load_i) begin
      q_d = d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/time_snapshot_bank.sv
module time_snapshot_bank
  import snap_pkg::*;
#(
  parameter int unsigned FIELD_W   = SNAP_FIELD_W,
  parameter int unsigned NUM_FIELD = SNAP_NUM_FIELD
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [FIELD_W*NUM_FIELD-1:0] live_fields_i,
  input  logic                         live_upd_i,
  input  logic                         en_wr_i,
  input  logic                         en_wdata_i,
  input  logic                         pwr_fail_i,
  output logic [FIELD_W*NUM_FIELD-1:0] snap_fields_o,
  output logic                         track_en_o
);

  localparam int unsigned VEC_W = FIELD_W * NUM_FIELD;

  logic      rst_sync_n;
  snap_ctl_t ctl;
  logic      track_en;
  logic      load_all;

  snap_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    ctl.wr    = en_wr_i;
    ctl.wdata = en_wdata_i;
    ctl.pf    = pwr_fail_i;
  end

  snap_enable_ctrl u_en_ctrl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ctl_i (ctl),
    .en_o  (track_en)
  );

  // one shared load term for every field: no mix of pre/post rollover bytes
  assign load_all = track_en & live_upd_i;

  for (genvar g = 0; g < NUM_FIELD; g++) begin : g_field
    snap_field_reg #(.W(FIELD_W)) u_field (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .load_i (load_all),
      .d_i    (live_fields_i[g*FIELD_W +: FIELD_W]),
      .q_o    (snap_fields_o[g*FIELD_W +: FIELD_W])
    );
  end

  assign track_en_o = track_en;

  // R2: a strobe while tracking copies every field on that edge
  assert_load_all_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (track_en_o && live_upd_i) |=> (snap_fields_o == $past(live_fields_i)));

  // R3 / R4: without a tracked strobe the snapshot is frozen
  assert_frozen_hold_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(track_en_o && live_upd_i) |=> $stable(snap_fields_o));

  // R1: reset state is visible on the ports
  always_comb begin
    if (rst_n === 1'b0) begin
      assert_reset_state_R1: assert (snap_fields_o == {VEC_W{1'b0}} && !track_en_o);
    end
  end

endmodule

// File: tb/time_snapshot_bank_tb.sv
module time_snapshot_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int FW = 8;
  localparam int NF = 7;
  localparam int VW = FW * NF;

  typedef struct {
    logic [VW-1:0] snap;
    logic          en;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [VW-1:0] live;
  logic          upd, wr, wdat, pf;
  logic [VW-1:0] snap_o;
  logic          en_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  exp_t sb_q[$];

  // bench model of the requirements
  logic [VW-1:0] m_snap;
  logic          m_en;
  logic          m_pfq;

  always #(CLK_PERIOD/2) clk = ~clk;

  time_snapshot_bank u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .live_fields_i (live),
    .live_upd_i    (upd),
    .en_wr_i       (wr),
    .en_wdata_i    (wdat),
    .pwr_fail_i    (pf),
    .snap_fields_o (snap_o),
    .track_en_o    (en_o)
  );

  // pack hh:mm:ss.cc plus date into the R10 field order
  function automatic logic [VW-1:0] tm(input logic [7:0] yr, mo, dy, hr, mi, se, hu);
    return {yr, mo, dy, hr, mi, se, hu};
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] a_s, e_s,
                       input logic a_e, e_e);
    checks++;
    if (a_s !== e_s || a_e !== e_e) begin
      errors++;
      $display("FAIL %s: snap=%h en=%b expected snap=%h en=%b", tag, a_s, a_e, e_s, e_e);
    end
  endtask

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(input string tag, input logic [VW-1:0] l, input logic u,
                      input logic w, input logic wd, input logic p);
    logic evt;
    exp_t it;
    @(negedge clk);
    live = l; upd = u; wr = w; wdat = wd; pf = p;
    if (m_en && u) m_snap = l;
    evt = p && !m_pfq;
    if (evt) m_en = 1'b0;
    else if (w) m_en = wd;
    m_pfq = p;
    it.snap = m_snap; it.en = m_en; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compares one scoreboard item per cycle after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        check(it.tag, snap_o, it.snap, en_o, it.en);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: expired, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    live = '0; upd = 0; wr = 0; wdat = 0; pf = 0;
    m_snap = '0; m_en = 0; m_pfq = 0;
    #1;
    check("R1 during reset", snap_o, '0, en_o, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1 after release", snap_o, '0, en_o, 1'b0);

    // R5: enable tracking
    step("R5 write 1", tm(8'h24, 8'h03, 8'h15, 8'h10, 8'h20, 8'h30, 8'h40), 0, 1, 1, 0);
    // R2 / R10: distinct byte per field
    step("R2 R10 load", tm(8'h07, 8'h06, 8'h05, 8'h04, 8'h03, 8'h02, 8'h01), 1, 0, 0, 0);
    // R3: live changes without strobe
    step("R3 no strobe", tm(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 8'h98), 0, 0, 0, 0);
    step("R3 no strobe b", tm(8'h11, 8'h11, 8'h11, 8'h11, 8'h11, 8'h11, 8'h11), 0, 0, 0, 0);
    step("R2 load 23:59:59.99", tm(8'h24, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 8'h99), 1, 0, 0, 0);
    // R4: freeze, then roll over
    step("R5 R4 write 0", tm(8'h24, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 8'h99), 0, 1, 0, 0);
    step("R4 rollover", tm(8'h25, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00), 1, 0, 0, 0);
    step("R4 after rollover", tm(8'h25, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01), 1, 0, 0, 0);
    step("R4 after rollover b", tm(8'h25, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h02), 1, 0, 0, 0);
    // R6: re-enable, then fail with strobe in same cycle
    step("R5 re-enable", tm(8'h25, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h03), 0, 1, 1, 0);
    step("R2 load C", tm(8'h25, 8'h01, 8'h01, 8'h08, 8'h15, 8'h42, 8'h10), 1, 0, 0, 0);
    step("R6 fail with strobe", tm(8'h25, 8'h01, 8'h01, 8'h08, 8'h15, 8'h42, 8'h11), 1, 0, 0, 1);
    step("R6 later strobe", tm(8'h25, 8'h01, 8'h01, 8'h08, 8'h15, 8'h42, 8'h12), 1, 0, 0, 1);
    // R9: held fail, host re-enables
    step("R9 write 1 while held", tm(8'h25, 8'h01, 8'h01, 8'h08, 8'h15, 8'h42, 8'h13), 0, 1, 1, 1);
    step("R9 tracking resumes", tm(8'h25, 8'h01, 8'h01, 8'h08, 8'h15, 8'h43, 8'h00), 1, 0, 0, 1);
    step("R9 drop fail", tm(8'h25, 8'h01, 8'h01, 8'h08, 8'h15, 8'h43, 8'h01), 0, 0, 0, 0);
    // R7: fail edge and write 1 together
    step("R7 fail beats write", tm(8'h25, 8'h01, 8'h01, 8'h08, 8'h15, 8'h43, 8'h02), 0, 1, 1, 1);
    step("R7 strobe ignored", tm(8'h25, 8'h02, 8'h02, 8'h02, 8'h02, 8'h02, 8'h02), 1, 0, 0, 1);
    step("R7 drop fail", tm(8'h25, 8'h02, 8'h02, 8'h02, 8'h02, 8'h02, 8'h03), 0, 0, 0, 0);
    // R8: flag already 0 when power fails
    step("R8 fail while frozen", tm(8'h30, 8'h04, 8'h04, 8'h04, 8'h04, 8'h04, 8'h04), 1, 0, 0, 1);
    step("R8 still frozen", tm(8'h30, 8'h05, 8'h05, 8'h05, 8'h05, 8'h05, 8'h05), 1, 0, 0, 0);

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
    end
    finish_run();
  end

endmodule